// File: doc/BRIEF.md
# Dual-Rate Programmable Output Divider

This block turns a fast single-bit source clock into two divided outputs. A main output runs at the source rate divided by 1, 2, 4 or 8, chosen by a 2-bit code. A companion output always runs at half the main rate and stays phase-locked to it. Each output also comes out as an inverted copy. The source is picked from three candidates: an oscillator clock (normal mode) or, in bypass mode, one of two reference clocks chosen by a reference-select input.

All logic runs on one system clock that is faster than any source. The selected source passes through a synchronizer. Every transition of the synchronized source, rising or falling, is one divider event. The main output toggles once every R events, where R is the ratio, so both outputs keep a 50% duty cycle even at a ratio of 1.

An active-high functional reset holds the dividers idle with the true outputs low. It leaves the applied ratio untouched. When it is released, both outputs restart together from a zero count. A new ratio code is applied only at the end of a main-output period, so no shortened pulse is produced.

Top module: `dual_rate_divider`

## Requirements
- R1: The applied code selects the ratio R as follows: code 00 gives 1, 01 gives 2, 10 gives 4 and 11 gives 8. Every high phase and every low phase of the main output lasts exactly R transitions of the selected source. The main output changes only on a source transition event.
- R2: Every high phase and every low phase of the half-rate output lasts exactly 2R source transitions. The half-rate output changes state only in the cycle in which the main output rises.
- R3: Both outputs have equal high and low phase lengths, which gives a 50% duty cycle.
- R4: While the functional reset `div_hold` is high, the divider counters stay at zero. One cycle after `div_hold` is sampled high, both true outputs are low and both inverted outputs are high.
- R5: `div_hold` does not change the applied ratio code. After release, the first output phases use the ratio that was in force before the hold.
- R6: After `div_hold` falls, the main and half-rate outputs rise in the same cycle, after R source transitions counted from zero.
- R7: When `pll_mode` is high, the oscillator clock `vco_clk` is the source. When `pll_mode` is low, the source is `ref_diff` if `ref_sel` is high and `ref_test` if `ref_sel` is low.
- R8: A change on `n_code` is applied only at the source event on which the main output falls. Every output phase therefore lasts either the full old ratio or the full new ratio, never a shortened count.
- R9: `main_out_n` and `half_out_n` are always the bitwise complement of `main_out` and `half_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than every source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_hold | input | 1 | Active-high functional reset of the dividers |
| pll_mode | input | 1 | High: oscillator clock is the source; low: bypass to the selected reference |
| ref_sel | input | 1 | High: `ref_diff` is the reference; low: `ref_test` is the reference |
| vco_clk | input | 1 | Oscillator clock, treated as a sampled signal |
| ref_diff | input | 1 | Primary reference clock, treated as a sampled signal |
| ref_test | input | 1 | Test reference clock, treated as a sampled signal |
| n_code | input | 2 | Requested divide-ratio code |
| main_out | output | 1 | Main divided output |
| main_out_n | output | 1 | Inverted main output |
| half_out | output | 1 | Half-rate output |
| half_out_n | output | 1 | Inverted half-rate output |

## Verification
The embedded assertions check, on every cycle, that the main output moves only on a source event and that the counter stays below the ratio. They also check that the half-rate output moves only when the main output rises, that the functional reset empties both outputs, and that the applied ratio changes only on a main-output falling event. Exact phase lengths cannot be seen one cycle at a time, and the bench scenarios cover them: the lengths for every ratio code and every source choice, the preserved ratio across a hold, the joint first rise after release, and the mix of old and new phase lengths around a ratio change.

// File: rtl/drd_pkg.sv
package drd_pkg;
  // Width of the ratio select code.
  localparam int NCODE_W = 2;
  // Largest ratio is 2**(2**NCODE_W - 1); this width holds it.
  localparam int RATIO_W = 1 << NCODE_W;
  // The event counter runs from 0 to ratio-1.
  localparam int CNT_W   = RATIO_W - 1;

  typedef logic [NCODE_W-1:0] ncode_t;
  typedef logic [RATIO_W-1:0] ratio_t;
  typedef logic [CNT_W-1:0]   cnt_t;

  // The ratio is a power of two chosen by the code.
  function automatic ratio_t code_to_ratio(input ncode_t code);
    return ratio_t'(1) << code;
  endfunction
endpackage

// File: rtl/drd_src_select.sv
module drd_src_select #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pll_mode,
  input  logic ref_sel,
  input  logic vco_clk,
  input  logic ref_diff,
  input  logic ref_test,
  output logic tick
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic               src_raw;
  logic [CHAIN_W-1:0] chain_q;
  logic [CHAIN_W-1:0] chain_d;

  // The oscillator has priority; in bypass mode ref_sel picks the reference.
  always_comb begin
    if (pll_mode) begin
      src_raw = vco_clk;
    end else if (ref_sel) begin
      src_raw = ref_diff;
    end else begin
      src_raw = ref_test;
    end
  end

  // Shift chain: SYNC_STAGES synchronizer flops plus one history flop.
  always_comb begin
    chain_d = {chain_q[CHAIN_W-2:0], src_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // Either transition of the synchronized source is one divider event.
  assign tick = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
endmodule

// File: rtl/drd_ratio_ctrl.sv
module drd_ratio_ctrl
  import drd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  ncode_t n_req,
  input  logic   fall_evt,
  output ratio_t ratio
);
  ncode_t n_cur_q;
  ncode_t n_cur_d;

  // The requested code is taken only at a main-output falling event.
  // The functional reset never produces that event, so the code survives it.
  always_comb begin
    n_cur_d = n_cur_q;
    if (fall_evt) begin
      n_cur_d = n_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cur_q <= '0;
    end else begin
      n_cur_q <= n_cur_d;
    end
  end

  assign ratio = code_to_ratio(n_cur_q);

  // R8
  code_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_evt |=> $stable(n_cur_q));
endmodule

// File: rtl/drd_div_core.sv
module drd_div_core
  import drd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   div_hold,
  input  logic   tick,
  input  ratio_t ratio,
  output logic   main_q,
  output logic   half_q,
  output logic   fall_evt
);
  cnt_t cnt_q;
  cnt_t cnt_d;
  logic main_d;
  logic half_d;
  logic last_evt;

  // The current phase ends on the ratio-th event.
  assign last_evt = ({1'b0, cnt_q} == (ratio - ratio_t'(1)));

  always_comb begin
    cnt_d  = cnt_q;
    main_d = main_q;
    half_d = half_q;
    if (div_hold) begin
      cnt_d  = '0;
      main_d = 1'b0;
      half_d = 1'b0;
    end else if (tick) begin
      if (last_evt) begin
        cnt_d  = '0;
        main_d = ~main_q;
        // The half-rate output toggles on every main rising event.
        half_d = main_q ? half_q : ~half_q;
      end else begin
        cnt_d = cnt_q + cnt_t'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      main_q <= 1'b0;
      half_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      main_q <= main_d;
      half_q <= half_d;
    end
  end

  assign fall_evt = tick & ~div_hold & last_evt & main_q;

  // R1
  main_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !div_hold) |=> $stable(main_q));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, cnt_q} < ratio));

  // R4
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |=> (!main_q && !half_q && (cnt_q == '0)));

  // R2
  half_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(div_hold) && (half_q != $past(half_q))) |-> $rose(main_q));
endmodule

// File: rtl/dual_rate_divider.sv
module dual_rate_divider
  import drd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               div_hold,
  input  logic               pll_mode,
  input  logic               ref_sel,
  input  logic               vco_clk,
  input  logic               ref_diff,
  input  logic               ref_test,
  input  logic [NCODE_W-1:0] n_code,
  output logic               main_out,
  output logic               main_out_n,
  output logic               half_out,
  output logic               half_out_n
);
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_int_n;
  logic                  tick;
  logic                  fall_evt;
  ratio_t                ratio;
  logic                  main_q;
  logic                  half_q;

  // Reset asserts at once and is released through a short flop chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe_q[RST_STAGES-1];

  drd_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .pll_mode (pll_mode),
    .ref_sel  (ref_sel),
    .vco_clk  (vco_clk),
    .ref_diff (ref_diff),
    .ref_test (ref_test),
    .tick     (tick)
  );

  drd_ratio_ctrl u_ratio (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .n_req    (n_code),
    .fall_evt (fall_evt),
    .ratio    (ratio)
  );

  drd_div_core u_div (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .div_hold (div_hold),
    .tick     (tick),
    .ratio    (ratio),
    .main_q   (main_q),
    .half_q   (half_q),
    .fall_evt (fall_evt)
  );

  assign main_out   = main_q;
  assign half_out   = half_q;
  assign main_out_n = ~main_q;
  assign half_out_n = ~half_q;
endmodule

// File: tb/sim_dual_rate_divider.sv
module sim_dual_rate_divider;
  localparam int HP_VCO  = 3;
  localparam int HP_DIFF = 5;
  localparam int HP_TEST = 7;

  logic clk = 1'b0;
  logic rst_n, div_hold, pll_mode, ref_sel;
  logic vco_clk, ref_diff, ref_test;
  logic [1:0] n_code;
  logic main_out, main_out_n, half_out, half_out_n;

  int total = 0;
  int fails = 0;
  int compl_bad = 0;

  always #2.5 clk = ~clk;

  dual_rate_divider u0 (
    .clk(clk), .rst_n(rst_n), .div_hold(div_hold), .pll_mode(pll_mode),
    .ref_sel(ref_sel), .vco_clk(vco_clk), .ref_diff(ref_diff),
    .ref_test(ref_test), .n_code(n_code), .main_out(main_out),
    .main_out_n(main_out_n), .half_out(half_out), .half_out_n(half_out_n)
  );

  // Free-running source clocks with distinct half-periods.
  initial begin vco_clk = 1'b0;  forever begin repeat (HP_VCO)  @(negedge clk); vco_clk  = ~vco_clk;  end end
  initial begin ref_diff = 1'b0; forever begin repeat (HP_DIFF) @(negedge clk); ref_diff = ~ref_diff; end end
  initial begin ref_test = 1'b0; forever begin repeat (HP_TEST) @(negedge clk); ref_test = ~ref_test; end end

  // R9: complement watched on every cycle.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if ((main_out_n !== ~main_out) || (half_out_n !== ~half_out)) compl_bad++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pick(input bit use_half);
    return use_half ? half_out : main_out;
  endfunction

  // Waits for a rising edge, then measures one high and one low phase in cycles.
  task automatic measure(input bit use_half, output int hi, output int lo);
    logic p, s;
    hi = 0; lo = 0;
    p = pick(use_half);
    for (int g = 0; g < 4000; g++) begin
      @(negedge clk);
      s = pick(use_half);
      if (!p && s) break;
      p = s;
    end
    while (pick(use_half) == 1'b1 && hi < 4000) begin hi++; @(negedge clk); end
    while (pick(use_half) == 1'b0 && lo < 4000) begin lo++; @(negedge clk); end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; div_hold = 1'b1; pll_mode = 1'b1; ref_sel = 1'b1; n_code = 2'b00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R4 main low in hold", int'(main_out), 0);
    chk("R4 half low in hold", int'(half_out), 0);
    chk("R9 main_n high in hold", int'(main_out_n), 1);
    chk("R9 half_n high in hold", int'(half_out_n), 1);
  endtask

  task automatic t_ratios();
    int hi, lo, r;
    div_hold = 1'b0; pll_mode = 1'b1;
    for (int c = 0; c < 4; c++) begin
      n_code = 2'(c);
      r = 1 << c;
      measure(1'b0, hi, lo);
      measure(1'b0, hi, lo);
      chk($sformatf("R1 main high code %0d", c), hi, r * HP_VCO);
      chk($sformatf("R3 main low code %0d", c), lo, r * HP_VCO);
      measure(1'b1, hi, lo);
      chk($sformatf("R2 half high code %0d", c), hi, 2 * r * HP_VCO);
      chk($sformatf("R3 half low code %0d", c), lo, 2 * r * HP_VCO);
    end
  endtask

  task automatic t_sources();
    int hi, lo;
    n_code = 2'b01;
    pll_mode = 1'b0; ref_sel = 1'b1;
    measure(1'b0, hi, lo); measure(1'b0, hi, lo);
    chk("R7 bypass ref_diff", hi, 2 * HP_DIFF);
    ref_sel = 1'b0;
    measure(1'b0, hi, lo); measure(1'b0, hi, lo);
    chk("R7 bypass ref_test", hi, 2 * HP_TEST);
    pll_mode = 1'b1;
    measure(1'b0, hi, lo); measure(1'b0, hi, lo);
    chk("R7 oscillator wins over ref_sel", hi, 2 * HP_VCO);
  endtask

  task automatic t_hold();
    int hi, lo, bad, tm, th, k;
    n_code = 2'b10;
    measure(1'b0, hi, lo); measure(1'b0, hi, lo);
    @(negedge clk);
    div_hold = 1'b1;
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (main_out || half_out || !main_out_n || !half_out_n) bad++;
    end
    chk("R4 outputs held over hold window", bad, 0);
    div_hold = 1'b0;
    tm = -1; th = -1; k = 0;
    for (int g = 0; g < 500; g++) begin
      @(negedge clk); k++;
      if (main_out && tm < 0) tm = k;
      if (half_out && th < 0) th = k;
      if (tm >= 0 && th >= 0) break;
    end
    chk("R6 main and half rise together", tm, th);
    hi = 0;
    while (main_out && hi < 4000) begin hi++; @(negedge clk); end
    chk("R5 ratio kept across hold", hi, 4 * HP_VCO);
  endtask

  // Collects complete phase lengths of main_out; each must be one of two values.
  task automatic run_watch(input int cycles, input int a, input int b,
                           output int bad, output int seen_a);
    logic p, s;
    int run;
    bit started;
    bad = 0; seen_a = 0; run = 0; started = 0;
    p = main_out;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      s = main_out;
      if (s == p) begin
        run++;
      end else begin
        if (started) begin
          if (run != a && run != b) bad++;
          if (run == a) seen_a++;
        end
        started = 1; run = 1; p = s;
      end
    end
  endtask

  task automatic t_switch();
    int hi, lo, bad, seen;
    n_code = 2'b11;
    measure(1'b0, hi, lo); measure(1'b0, hi, lo);
    chk("R1 ratio 8 before switch", hi, 8 * HP_VCO);
    measure(1'b0, hi, lo);
    repeat (7) @(negedge clk);
    n_code = 2'b00;
    run_watch(400, HP_VCO, 8 * HP_VCO, bad, seen);
    chk("R8 no short phase going 8 to 1", bad, 0);
    chk("R8 new ratio reached", int'(seen > 0), 1);
    repeat (2) @(negedge clk);
    n_code = 2'b11;
    run_watch(400, 8 * HP_VCO, HP_VCO, bad, seen);
    chk("R8 no short phase going 1 to 8", bad, 0);
    chk("R8 ratio 8 reached again", int'(seen > 0), 1);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_ratios();
    t_sources();
    t_hold();
    t_switch();
    chk("R9 complement mismatches", compl_bad, 0);
    finish_run();
  end
endmodule